// File: doc/BRIEF.md
# Dual bit-clock timer for a serial port

The block holds two matching 16-bit timers, one that paces the transmit side of a serial port and one that paces the receive side. Each timer counts either the system clock divided by two or an external clock. When the count reaches a programmable period value, the count goes back to 0 and the timer acts on its output in one of two ways. In clock form the output changes level at every wrap, which gives a square wave with a 50% duty cycle. In pulse form the output goes high for a single system clock cycle at every wrap. The output drives a pin, and software can also read it as a status bit.

Software reaches the block through a plain register bus. The bus has a shared 32-bit control word, plus a period register and a counter register for each timer. Each timer has three controls. The first is a restart bit, which zeroes the count and then clears itself. The second is an active-low hold. The hold freezes the count and also the internal divide-by-two stage, so counting picks up exactly where it stopped. The third selects the clock source.

Top module: `sport_timer_pair`

## Requirements
- R1: After reset, every register reads 0 and both outputs are low.
- R2: Address 0 holds the control word. Address 1 holds the transmit period and address 2 the transmit counter. Address 3 holds the receive period and address 4 the receive counter. Read data appears one cycle after the address. Period and counter registers keep only their low counter-width bits and read 0 above them.
- R3: Each timer has a 6-bit field in the control word, starting at bit 0 for transmit and bit 6 for receive. Inside a field, bit 0 is go, bit 1 is hold (1 = run), bit 2 is mode (1 = clock form, 0 = pulse form), bit 3 is source (1 = internal), bit 4 is reserved and bit 5 is status. Bits 4, 10 and 31..12 always read 0, and a write to a status bit has no effect.
- R4: A control write with go=1 and hold=1 in a field does three things to that timer: it zeroes the counter, clears its output and restarts the divide-by-two stage. Go then reads 1 until the next timer clock tick and reads 0 after that tick.
- R5: A control write with go=1 and hold=0 leaves the counter unchanged, and go reads 0. A write with go=0 does not zero the counter.
- R6: While hold=0, the counter and the divide-by-two stage are frozen. After hold returns to 1, the count matches a timer that was never held and ran for the same number of running cycles.
- R7: With the internal source, the counter steps once every two system clock cycles. After it reaches the period value, it wraps to 0. Counted n cycles after a go write, the value is floor(n/2) mod (period+1).
- R8: In clock form, the output toggles at each wrap. After n cycles from a go write, the output level equals floor(floor(n/2)/(period+1)) mod 2.
- R9: In pulse form, the output is high for exactly one cycle at each wrap. It is high n cycles after a go write exactly when n is even, n>0, and (n/2) mod (period+1) = 0.
- R10: With the external source, each rising edge of the external clock input moves the counter by one, after the edge passes through a synchronizer. While hold=0, external edges are ignored.
- R11: A bus write to a counter register loads that value into the counter.
- R12: Activity on one timer does not change the other timer's output or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_ext_clk | input | 1 | External clock for the transmit timer |
| rx_ext_clk | input | 1 | External clock for the receive timer |
| tx_clk_out | output | 1 | Transmit timer output |
| rx_clk_out | output | 1 | Receive timer output |

## Verification
The bench builds the block with an 8-bit counter width and two synchronizer stages. The 8-bit width makes the truncation of wide writes to the period register visible. The bench sweeps periods 0 to 5 and every cycle offset after a go write, so every wrap phase of both output forms is compared against closed-form expressions. It also runs a held timer and an unheld timer for the same number of running cycles. A divide-by-two stage that kept running while held would show up as a difference between the two counts.

// File: rtl/sport_tmr_pkg.sv
package sport_tmr_pkg;
  localparam int NCH      = 2;
  localparam int FLD_W    = 6;
  localparam int GO_B     = 0;
  localparam int HOLD_B   = 1;
  localparam int MODE_B   = 2;
  localparam int SRC_B    = 3;
  localparam int RSV_B    = 4;
  localparam int STAT_B   = 5;
  localparam int CTRL_USED = FLD_W * NCH;
  localparam int A_CTRL   = 0;

  function automatic int per_addr(input int ch);
    return 1 + 2 * ch;
  endfunction

  function automatic int cnt_addr(input int ch);
    return 2 + 2 * ch;
  endfunction
endpackage

// File: rtl/sport_tmr_tick.sv
module sport_tmr_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic src_int,
  input  logic restart,
  input  logic ext_clk,
  output logic tick
);
  logic                   phase_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_rise;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= 1'b0;
    end else if (run && src_int) begin
      phase_q <= ~phase_q;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ext_clk;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign tick     = run & (src_int ? phase_q : ext_rise);
endmodule

// File: rtl/sport_tmr_chan.sv
module sport_tmr_chan #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_req,
  input  logic             run,
  input  logic             clk_mode,
  input  logic             src_int,
  input  logic             ext_clk,
  input  logic [CNT_W-1:0] period,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt_ld_val,
  output logic [CNT_W-1:0] count,
  output logic             go_flag,
  output logic             stat
);
  logic tick;
  logic wrap;

  sport_tmr_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .src_int (src_int),
    .restart (go_req),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  assign wrap = tick && (count == period);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      go_flag <= 1'b0;
      stat    <= 1'b0;
    end else if (go_req) begin
      count   <= '0;
      go_flag <= 1'b1;
      stat    <= 1'b0;
    end else if (cnt_ld) begin
      count <= cnt_ld_val;
      if (!clk_mode) stat <= 1'b0;
    end else begin
      if (tick) begin
        go_flag <= 1'b0;
        count   <= wrap ? '0 : count + 1'b1;
      end
      if (clk_mode) stat <= wrap ? ~stat : stat;
      else          stat <= wrap;
    end
  end
endmodule

// File: rtl/sport_timer_pair.sv
module sport_timer_pair
  import sport_tmr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_ext_clk,
  input  logic              rx_ext_clk,
  output logic              tx_clk_out,
  output logic              rx_clk_out
);
  logic [NCH-1:0]            hold_q, mode_q, src_q;
  logic [NCH-1:0]            go_w, stat_w, go_req, cnt_ld;
  logic [NCH-1:0]            ext_in;
  logic [NCH-1:0][CNT_W-1:0] per_q, cnt_w;
  logic [DATA_W-1:0]         rd_mux;
  logic                      ctrl_wr;
  logic                      unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign ext_in  = {rx_ext_clk, tx_ext_clk};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int BASE = FLD_W * i;

      assign go_req[i] = ctrl_wr && bus_wdata[BASE+GO_B] && bus_wdata[BASE+HOLD_B];
      assign cnt_ld[i] = bus_wr && (bus_addr == ADDR_W'(cnt_addr(i)));

      always_ff @(posedge clk) begin
        if (rst) begin
          hold_q[i] <= 1'b0;
          mode_q[i] <= 1'b0;
          src_q[i]  <= 1'b0;
        end else if (ctrl_wr) begin
          hold_q[i] <= bus_wdata[BASE+HOLD_B];
          mode_q[i] <= bus_wdata[BASE+MODE_B];
          src_q[i]  <= bus_wdata[BASE+SRC_B];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          per_q[i] <= '0;
        end else if (bus_wr && (bus_addr == ADDR_W'(per_addr(i)))) begin
          per_q[i] <= bus_wdata[CNT_W-1:0];
        end
      end

      sport_tmr_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
        .clk        (clk),
        .rst        (rst),
        .go_req     (go_req[i]),
        .run        (hold_q[i]),
        .clk_mode   (mode_q[i]),
        .src_int    (src_q[i]),
        .ext_clk    (ext_in[i]),
        .period     (per_q[i]),
        .cnt_ld     (cnt_ld[i]),
        .cnt_ld_val (bus_wdata[CNT_W-1:0]),
        .count      (cnt_w[i]),
        .go_flag    (go_w[i]),
        .stat       (stat_w[i])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) begin
      for (int i = 0; i < NCH; i++) begin
        rd_mux[FLD_W*i +: FLD_W] = {stat_w[i], 1'b0, src_q[i], mode_q[i], hold_q[i], go_w[i]};
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr == ADDR_W'(per_addr(i))) rd_mux[CNT_W-1:0] = per_q[i];
        if (bus_addr == ADDR_W'(cnt_addr(i))) rd_mux[CNT_W-1:0] = cnt_w[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign tx_clk_out = stat_w[0];
  assign rx_clk_out = stat_w[1];
endmodule

// File: rtl/sport_tmr_chk.sv
module sport_tmr_chk
  import sport_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NCH-1:0]            hold,
  input logic [NCH-1:0]            mode,
  input logic [NCH-1:0]            go,
  input logic [NCH-1:0]            outs,
  input logic [NCH-1:0][CNT_W-1:0] cnt
);
  logic unused_rd;
  assign unused_rd = ^bus_rdata;

  // R3: reserved control bits read as zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr) == ADDR_W'(A_CTRL) |->
      (bus_rdata[DATA_W-1:CTRL_USED] == '0) && !bus_rdata[RSV_B] && !bus_rdata[FLD_W+RSV_B]);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_c
      // R4: go rising coincides with a zeroed counter and a cleared output
      a_r4_go_zeroes: assert property (@(posedge clk) disable iff (rst)
        $rose(go[i]) |-> (cnt[i] == '0) && !outs[i]);

      // R6: a held timer keeps its count while the bus is quiet
      a_r6_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        !hold[i] && !bus_wr |=> $stable(cnt[i]));

      // R7: without bus writes the count moves by at most one or wraps
      a_r7_step_or_wrap: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> (cnt[i] == $past(cnt[i])) || (cnt[i] == CNT_W'($past(cnt[i]) + 1'b1))
                    || (cnt[i] == '0));

      // R8: in clock form the output changes only together with a zero count
      a_r8_toggle_at_wrap: assert property (@(posedge clk) disable iff (rst)
        $past(mode[i]) && (outs[i] != $past(outs[i])) |-> cnt[i] == '0);

      // R9: a pulse lasts a single cycle
      a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        !mode[i] && outs[i] |=> !outs[i]);
    end
  endgenerate
endmodule

bind sport_timer_pair sport_tmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .hold      (hold_q),
  .mode      (mode_q),
  .go        (go_w),
  .outs      (stat_w),
  .cnt       (cnt_w)
);

// File: tb/sim_sport_timer_pair.sv
`timescale 1ns/1ps
module sim_sport_timer_pair;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_ext_clk = 1'b0;
  logic        rx_ext_clk = 1'b0;
  logic        tx_clk_out, rx_clk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sport_timer_pair #(.DATA_W(32), .ADDR_W(3), .CNT_W(CW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_ext_clk(tx_ext_clk), .rx_ext_clk(rx_ext_clk),
    .tx_clk_out(tx_clk_out), .rx_clk_out(rx_clk_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [5:0] fld(input bit go, input bit hold, input bit cp, input bit src);
    return {2'b00, src, cp, hold, go};
  endfunction

  function automatic logic [31:0] cw(input int ch, input logic [5:0] f);
    return (ch == 0) ? {26'd0, f} : {20'd0, f, 6'd0};
  endfunction

  task automatic ext_pulses(input int ch, input int k);
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      if (ch == 0) tx_ext_clk = 1'b1; else rx_ext_clk = 1'b1;
      idle(3);
      @(negedge clk);
      if (ch == 0) tx_ext_clk = 1'b0; else rx_ext_clk = 1'b0;
      idle(3);
    end
    idle(8);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v, v2;
    logic o_exp, other0;
    int pers[4];
    pers = '{0, 1, 2, 5};
    idle(3);
    @(negedge clk) rst = 1'b0;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 reset read", d, 0);
    end
    chk(!tx_clk_out && !rx_clk_out, "R1 outputs low", {tx_clk_out, rx_clk_out}, 0);

    // R2 register map and width truncation
    wr(1, 32'h0000_FFFF); rd(1, d);
    chk(d == 32'hFF, "R2 tx period truncated", d, 32'hFF);
    wr(3, 32'h5A); rd(3, d);
    chk(d == 32'h5A, "R2 rx period", d, 32'h5A);
    rd(1, d);
    chk(d == 32'hFF, "R2 tx period kept", d, 32'hFF);
    wr(1, 0); wr(3, 0);

    // R3 status bits not writable, reserved bits read zero
    wr(0, 32'h0000_0820); rd(0, d);
    chk(d == 0, "R3 status write ignored", d, 0);
    wr(0, 32'hFFFF_FFFF); rd(0, d);
    chk(d == 32'h3CF, "R3 reserved zero", d, 32'h3CF);
    wr(0, 0);

    // R7 internal source counting and wrap
    for (int pi = 0; pi < 4; pi++) begin
      wr(1, pers[pi]);
      for (int n = 0; n < 14; n++) begin
        wr(0, cw(0, fld(1, 1, 1, 1)));
        idle(n);
        rd(2, d);
        v = (n / 2) % (pers[pi] + 1);
        chk(d == v, "R7 count value", d, v);
      end
    end
    wr(0, 0);

    // R8 clock form, R9 pulse form, R12 other channel untouched
    for (int ch = 0; ch < 2; ch++) begin
      for (int cp = 0; cp < 2; cp++) begin
        for (int pi = 0; pi < 3; pi++) begin
          wr(3'(1 + 2 * ch), pers[pi]);
          wr(0, cw(ch, fld(1, 1, cp[0], 1)));
          other0 = (ch == 0) ? rx_clk_out : tx_clk_out;
          for (int n = 1; n <= 4 * (pers[pi] + 1) + 2; n++) begin
            idle(1);
            if (cp == 1)
              o_exp = (((n / 2) / (pers[pi] + 1)) % 2) == 1;
            else
              o_exp = (n % 2 == 0) && (((n / 2) % (pers[pi] + 1)) == 0);
            d = (ch == 0) ? tx_clk_out : rx_clk_out;
            chk(d[0] == o_exp, (cp == 1) ? "R8 clock form output" : "R9 pulse form output", d, o_exp);
            v = (ch == 0) ? rx_clk_out : tx_clk_out;
            chk(v[0] == other0, "R12 other output unchanged", v, other0);
          end
        end
        wr(0, 0);
      end
    end
    rd(2, d);
    wr(0, cw(1, fld(1, 1, 0, 1)));
    idle(9);
    rd(2, v);
    chk(v == d, "R12 tx counter unchanged by rx", v, d);
    wr(0, 0);

    // R4 go bit self clears on the next tick
    wr(1, 100);
    wr(0, cw(0, fld(1, 1, 0, 1)));
    rd(0, d);
    chk(d == 32'h0B, "R4 go reads one", d, 32'h0B);
    rd(0, d);
    rd(0, d);
    chk(d == 32'h0A, "R4 go cleared after tick", d, 32'h0A);
    wr(0, cw(0, fld(1, 1, 0, 0)));
    idle(10);
    rd(0, d);
    chk(d == 32'h03, "R4 go waits for ext tick", d, 32'h03);
    ext_pulses(0, 1);
    rd(0, d);
    chk(d == 32'h02, "R4 go cleared by ext tick", d, 32'h02);

    // R6 hold freezes counter and prescaler
    wr(0, cw(0, fld(1, 1, 0, 1)));
    idle(11);
    rd(2, d);
    chk(d == 5, "R6 unheld reference", d, 5);
    wr(0, cw(0, fld(1, 1, 0, 1)));
    idle(4);
    wr(0, cw(0, fld(0, 0, 0, 1)));
    rd(2, d);
    idle(5);
    rd(2, v);
    chk(d == 2 && v == 2, "R6 held count frozen", v, 2);
    wr(0, cw(0, fld(0, 1, 0, 1)));
    idle(6);
    rd(2, d);
    chk(d == 5, "R6 resumed exactly", d, 5);

    // R5 go while held and go=0 have no effect
    wr(0, cw(0, fld(0, 0, 0, 1)));
    rd(2, v);
    wr(0, cw(0, fld(1, 0, 0, 1)));
    rd(2, d);
    chk(d == v && v != 0, "R5 go ignored while held", d, v);
    rd(0, d);
    chk(d == 32'h08, "R5 go stays clear", d, 32'h08);
    wr(0, cw(0, fld(0, 1, 0, 1)));
    idle(3);
    rd(2, d);
    chk(d >= v, "R5 go zero keeps count", d, v);

    // R11 counter load
    wr(0, 0);
    wr(2, 77);
    rd(2, d);
    chk(d == 77, "R11 counter load", d, 77);
    wr(4, 33);
    rd(4, d);
    chk(d == 33, "R11 rx counter load", d, 33);

    // R10 external clock counting and hold
    wr(1, 4);
    wr(0, cw(0, fld(1, 1, 0, 0)));
    ext_pulses(0, 7);
    rd(2, d);
    chk(d == 2, "R10 tx ext count", d, 2);
    wr(0, cw(0, fld(0, 0, 0, 0)));
    ext_pulses(0, 3);
    rd(2, d);
    chk(d == 2, "R10 ext ignored while held", d, 2);
    wr(3, 2);
    wr(0, cw(1, fld(1, 1, 0, 0)));
    ext_pulses(1, 5);
    rd(4, d);
    chk(d == 2, "R10 rx ext count", d, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule